// File: doc/BRIEF.md
# Chained Shift-Buffer Parallel Pixel Serializer

This block drives a byte-wide parallel pixel bus from a chain of word-wide shift buffers. With the defaults there are four 32-bit buffers connected in series. That gives 128 bits, or sixteen 8-bit pixels, per burst. A data mover loads the buffers through a plain write port, writing the buffer with the highest index last. Only buffer 0 feeds the output pins. Each higher buffer shifts its low byte down into the buffer below it, so one burst empties the whole chain.

The write to the last buffer sets its full flag. That flag is the trigger for a baud-style pacing timer. The timer is built from two counters: a half-period counter loaded with DIV/2-1, and an edge counter loaded with 2*PIX_PER_BURST-1. The timer generates the pixel clock. It presents a new byte on each falling edge and stops by itself after the programmed number of edges. While the timer is running or a burst is pending, the request line stays low. It rises only when the chain has been fully emptied, so the data mover always refills all buffers in one go. The length of a video line must therefore be a multiple of the burst size.

Top module: `pxs_serializer`

## Requirements
- R1: After reset, pix_out is 0, pix_clk is 0, xfer_active is 0, dreq is 1 and ovr_err is 0.
- R2: A write with wr_sel 0, 1 or 2 loads that buffer and starts nothing, and dreq stays high. A write with wr_sel 3 (the last buffer) lowers dreq at once. On the clock edge after that write, xfer_active rises and the first pixel appears on pix_out.
- R3: Pixels leave in this order: buffer 0 first, then buffer 1, buffer 2 and buffer 3. Within each 32-bit word, bits [7:0] go first and bits [31:24] go last. Sixteen pixels go out per burst.
- R4: When the burst starts, pix_clk is low. It then toggles every DIV/2 clock cycles. pix_out changes only when pix_clk falls, so each pixel is held for exactly DIV cycles.
- R5: xfer_active stays high for exactly 16*DIV cycles. It then falls, with pix_clk low, and dreq rises in the same cycle.
- R6: While no burst is running, pix_out keeps the last pixel sent.
- R7: While a burst is running or pending, any write is ignored. A buffer that has not been rewritten since the previous burst sends zero bytes.
- R8: A write with wr_sel 3 while a burst is running raises ovr_err for exactly one cycle, in the cycle after the write. Writes to other buffers never raise ovr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 2 | Index of the buffer to write (3 = last buffer, the trigger) |
| wr_data | input | 32 | Word to load |
| dreq | output | 1 | Chain empty and idle: request the next burst |
| ovr_err | output | 1 | One-cycle pulse: last-buffer write during a burst |
| pix_out | output | 8 | Parallel pixel bus |
| pix_clk | output | 1 | Pixel clock; data changes on its falling edge |
| xfer_active | output | 1 | Timer running |

## Verification
The first burst uses ascending byte values, so each pixel is distinct. Any swap of buffer order or of byte order within a word then shows up as a wrong value at a known position. A second burst uses mixed bytes with contrasting high and low halves. During that burst the bench injects an overrun write to the last buffer and an ignored write to buffer 0, which separates the overrun pulse from the quiet drop of other writes. A third burst loads only the last buffer. The first twelve pixels must then be zero, which shows that the chain was drained and that the write made during the burst was not taken. Every burst is sampled in every cycle, so the pixel-clock phase, the hold time of each pixel, the exact stop cycle and the idle hold are all checked against cycle counts derived from DIV.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   // Default geometry of the serializer
   localparam int unsigned DEF_PIX_W   = 8;
   localparam int unsigned DEF_WORD_W  = 32;
   localparam int unsigned DEF_NUM_BUF = 4;
   localparam int unsigned DEF_DIV     = 4;
   localparam int unsigned DEF_CNT_W   = 8;

   // Number of pixels held in the whole chain
   function automatic int unsigned pix_per_burst(input int unsigned word_w,
                                                 input int unsigned pix_w,
                                                 input int unsigned nbuf);
      return (word_w / pix_w) * nbuf;
   endfunction
endpackage

// File: rtl/pxs_stage.sv
// One shift buffer of the chain: loadable word, shifts right by one pixel,
// taking the incoming pixel from the neighbour above.
module pxs_stage #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned PIX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_data,
   input  logic              shift,
   input  logic [PIX_W-1:0]  shift_in,
   output logic [PIX_W-1:0]  low_pix
);
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (shift)
         word_q <= {shift_in, word_q[WORD_W-1:PIX_W]};
      else if (load)
         word_q <= load_data;
   end

   assign low_pix = word_q[PIX_W-1:0];
endmodule

// File: rtl/pxs_timer.sv
// Dual-counter baud timer: low counter sets the half period, high counter
// counts pixel-clock edges. Output idles low; disables itself on compare.
module pxs_timer #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned CMP_LO = 1,
   parameter int unsigned CMP_HI = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic sclk,
   output logic fall
);
   logic [CNT_W-1:0] lo_q, hi_q;
   logic             expire;

   assign expire = active && (lo_q == '0);
   assign fall   = expire && (hi_q != '0) && sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk   <= 1'b0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else if (start) begin
         active <= 1'b1;
         sclk   <= 1'b0;
         lo_q   <= CNT_W'(CMP_LO);
         hi_q   <= CNT_W'(CMP_HI);
      end else if (active) begin
         if (!expire) begin
            lo_q <= lo_q - 1'b1;
         end else begin
            lo_q <= CNT_W'(CMP_LO);
            if (hi_q == '0) begin
               active <= 1'b0;
               sclk   <= 1'b0;
            end else begin
               hi_q <= hi_q - 1'b1;
               sclk <= ~sclk;
            end
         end
      end
   end
endmodule

// File: rtl/pxs_serializer.sv
module pxs_serializer
   import pxs_pkg::*;
#(
   parameter int unsigned PIX_W   = DEF_PIX_W,
   parameter int unsigned WORD_W  = DEF_WORD_W,
   parameter int unsigned NUM_BUF = DEF_NUM_BUF,
   parameter int unsigned DIV     = DEF_DIV,
   parameter int unsigned CNT_W   = DEF_CNT_W,
   localparam int unsigned SEL_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic              dreq,
   output logic              ovr_err,
   output logic [PIX_W-1:0]  pix_out,
   output logic              pix_clk,
   output logic              xfer_active
);
   localparam int unsigned BURST  = pix_per_burst(WORD_W, PIX_W, NUM_BUF);
   localparam int unsigned CMP_HI = BURST * 2 - 1;
   localparam int unsigned CMP_LO = DIV / 2 - 1;
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_BUF - 1);

   // Elaboration-time parameter checks
   generate
      if (WORD_W % PIX_W != 0 || WORD_W < 2 * PIX_W)
         $error("WORD_W must be a multiple of PIX_W holding at least two pixels");
      if (DIV < 2 || DIV % 2 != 0)
         $error("DIV must be even and at least 2");
      if (CMP_HI >= (1 << CNT_W) || CMP_LO >= (1 << CNT_W))
         $error("timer compare values do not fit CNT_W");
   endgenerate

   logic             full_last;
   logic             busy, wr_ok, start, fall, shift;
   logic [PIX_W-1:0] low_pix [NUM_BUF];
   logic [PIX_W-1:0] pins_q;
   logic             ovr_q;

   assign busy  = xfer_active | full_last;
   assign wr_ok = wr_en & ~busy;
   assign start = full_last & ~xfer_active;
   assign shift = start | fall;

   // Chain of shift buffers; stage i takes its input from stage i+1
   generate
      for (genvar i = 0; i < NUM_BUF; i++) begin : g_stage
         logic [PIX_W-1:0] feed;
         if (i == NUM_BUF - 1) begin : g_top
            assign feed = '0;
         end else begin : g_mid
            assign feed = low_pix[i+1];
         end
         pxs_stage #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_ok && (wr_sel == SEL_W'(i))),
            .load_data(wr_data),
            .shift    (shift),
            .shift_in (feed),
            .low_pix  (low_pix[i])
         );
      end
   endgenerate

   pxs_timer #(.CNT_W(CNT_W), .CMP_LO(CMP_LO), .CMP_HI(CMP_HI)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .active(xfer_active),
      .sclk  (pix_clk),
      .fall  (fall)
   );

   // Status flag of the last buffer, output pins and overrun pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_last <= 1'b0;
         pins_q    <= '0;
         ovr_q     <= 1'b0;
      end else begin
         if (start)
            full_last <= 1'b0;
         else if (wr_ok && wr_sel == LAST_SEL)
            full_last <= 1'b1;
         if (shift)
            pins_q <= low_pix[0];
         ovr_q <= wr_en && (wr_sel == LAST_SEL) && busy;
      end
   end

   assign pix_out = pins_q;
   assign ovr_err = ovr_q;
   assign dreq    = ~full_last & ~xfer_active;
endmodule

// File: rtl/pxs_serializer_chk.sv
module pxs_serializer_chk #(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [SEL_W-1:0]  wr_sel,
   input logic [WORD_W-1:0] wr_data,
   input logic              dreq,
   input logic              ovr_err,
   input logic [PIX_W-1:0]  pix_out,
   input logic              pix_clk,
   input logic              xfer_active
);
   AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |-> !pix_clk);                                  // R4
   AST_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && $rose(pix_clk)) |-> $stable(pix_out));       // R4
   AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> !xfer_active);                                      // R7
   AST_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_active) |-> dreq);                                // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_active && $past(!xfer_active)) |-> $stable(pix_out)); // R6
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err |-> $past(wr_en && wr_sel == {SEL_W{1'b1}}));        // R8
   AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err |=> !ovr_err);                                       // R8
   AST_WDATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$isunknown(wr_data));                             // R2
endmodule

bind pxs_serializer pxs_serializer_chk #(
   .PIX_W(PIX_W), .WORD_W(WORD_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .dreq(dreq), .ovr_err(ovr_err), .pix_out(pix_out),
   .pix_clk(pix_clk), .xfer_active(xfer_active)
);

// File: tb/tb_pxs_serializer.sv
`timescale 1ns/1ps
module tb_pxs_serializer;
   localparam int DIV   = 4;
   localparam int HALF  = DIV / 2;
   localparam int NPIX  = 16;
   localparam int TSPAN = NPIX * DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        dreq, ovr_err, pix_clk, xfer_active;
   logic [7:0]  pix_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pxs_serializer #(.DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .dreq(dreq), .ovr_err(ovr_err), .pix_out(pix_out),
      .pix_clk(pix_clk), .xfer_active(xfer_active)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive at a falling edge, captured at the next rising edge
   task automatic write_word(input logic [1:0] sel, input logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 pix_out", pix_out, 0);
      check("R1 pix_clk", pix_clk, 0);
      check("R1 active", xfer_active, 0);
      check("R1 dreq", dreq, 1);
      check("R1 ovr_err", ovr_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Send one burst; w holds the words the pins are expected to carry
   task automatic t_burst(input logic [31:0] w [4], input bit fill_low, input bit inject);
      logic [7:0] last_pix;
      if (fill_low) begin
         for (int i = 0; i < 3; i++) write_word(2'(i), w[i]);
         check("R2 no start before last", xfer_active, 0);
         check("R2 dreq before last", dreq, 1);
      end
      write_word(2'd3, w[3]);
      check("R2 dreq low after last", dreq, 0);
      check("R2 not yet active", xfer_active, 0);
      for (int t = 0; t <= TSPAN; t++) begin
         @(negedge clk);
         if (t < TSPAN) begin
            check("R3 pixel", pix_out, 32'(w[(t/DIV)/4][8*((t/DIV)%4) +: 8]));
            check("R4 pix_clk", pix_clk, 32'((t / HALF) % 2));
            check("R5 active", xfer_active, 1);
            check("R7 dreq busy", dreq, 0);
         end else begin
            check("R5 stop active", xfer_active, 0);
            check("R5 stop clk", pix_clk, 0);
            check("R5 dreq", dreq, 1);
            check("R6 last pixel", pix_out, 32'(w[3][31:24]));
         end
         check("R8 ovr_err", ovr_err, 32'(inject && t == 4));
         if (inject && t == 3) begin
            wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'hDEAD_BEEF;
         end else if (inject && t == 4) begin
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h5555_5555;
         end else begin
            wr_en = 1'b0;
         end
      end
      last_pix = pix_out;
      repeat (5) @(negedge clk);
      check("R6 idle hold", pix_out, 32'(last_pix));
      check("R6 idle clk", pix_clk, 0);
   endtask

   initial begin
      logic [31:0] wa [4];
      logic [31:0] wb [4];
      logic [31:0] wc [4];
      wa = '{32'h0302_0100, 32'h0706_0504, 32'h0B0A_0908, 32'h0F0E_0D0C};
      wb = '{32'hF00F_A55A, 32'h1234_80FF, 32'h7E81_C33C, 32'h9966_0110};
      wc = '{32'h0, 32'h0, 32'h0, 32'hCAFE_4321};
      t_reset();
      t_burst(wa, 1'b1, 1'b0);
      t_burst(wb, 1'b1, 1'b1);
      // R7: only the last buffer rewritten; the ignored write must not appear
      t_burst(wc, 1'b0, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule